// File: doc/BRIEF.md
# Test Output Selector with Divider Bypass

This block drives one test pin from a 3-bit test code. It also holds the two clock dividers whose outputs can be observed on that pin. The feedback M counter divides its source by a programmable value. The output N divider produces the divided clock output. The block is meant for production test and board-level debug. It can put a constant level, the reference clock, the serial shift-register output, the M counter pulse, the divided clock or a quarter-rate copy of the divided clock on the pin. One test code reroutes the slow serial clock into both dividers in place of the VCO clock.

The block is a single-clock model. Every clock source is an enable that is sampled on `clk`. A high `vco_tick` marks one edge of the VCO clock, and a high `ser_tick` marks one edge of the serial clock, rising and falling edges alternating. The divider source is chosen by picking one of the two enables, so the switch between sources cannot produce a glitch. The reference clock and the shift-register output arrive as levels.

Top module: `test_out_mux`

## Requirements
- R1: Test code 3'b001 drives the test pin high, and code 3'b101 drives it low, whatever the other inputs are.
- R2: Test code 3'b000 passes `shift_in` to the test pin, and code 3'b010 passes `ref_in`, both without a register delay.
- R3: Divider code 2'b00, 2'b01, 2'b10 and 2'b11 sets `fout` to the source divided by 1, 2, 4 and 8. Over 32 consecutive source ticks, `fout` changes level 32, 16, 8 and 4 times.
- R4: For every test code except 3'b110, the dividers advance only on `vco_tick`, and `ser_tick` has no effect on `fout`.
- R5: Test code 3'b110 selects bypass. The dividers advance only on `ser_tick`, `vco_tick` has no effect on `fout`, and the test pin shows the M counter pulse.
- R6: Under test code 3'b011, the M counter pulse on the test pin rises once every M source cycles, which is 2*M ticks. It is high for one source cycle only, so its duty cycle is not 50% for M > 2.
- R7: An M value of zero holds the M counter pulse low.
- R8: Test code 3'b111 shows `fout` divided by 4, so its period is four `fout` periods.
- R9: After synchronous reset, `fout` is low, and the quarter-rate and M counter outputs are low.
- R10: A change of test code clears the quarter-rate counter. A code of 3'b111 entered after a change shows low until `fout` rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock that samples every source enable |
| rst | input | 1 | Synchronous active-high reset |
| vco_tick | input | 1 | One VCO clock edge this cycle |
| ser_tick | input | 1 | One serial clock edge this cycle |
| ref_in | input | 1 | Reference clock level |
| shift_in | input | 1 | Serial shift-register output level |
| tsel | input | 3 | Test code for the test pin |
| nsel | input | 2 | Output divider code |
| mval | input | 9 | M counter divide value |
| test_pin | output | 1 | Selected test signal |
| fout | output | 1 | Divided clock output |

## Verification
The quarter-rate counter clear on a code change is the hardest case to reach. It needs the quarter output to be high at the moment the code changes. The stimulus runs code 3'b111 until the pin reads high, then stops all ticks so `fout` cannot rise. It then moves to another code and back, and expects the pin low. Bypass needs a second kind of care. Both enables are driven in turn, one at a time, so that a divider which follows the wrong source shows a frozen or moving `fout`.

// File: rtl/test_out_pkg.sv
package test_out_pkg;

    localparam int M_W    = 9;
    localparam int NDIV_W = 4;   // one phase bit plus ratios up to 8
    localparam int QDIV_W = 2;

    typedef enum logic [2:0] {
        TS_SHIFT   = 3'b000,
        TS_HIGH    = 3'b001,
        TS_REF     = 3'b010,
        TS_MCOUNT  = 3'b011,
        TS_FOUT    = 3'b100,
        TS_LOW     = 3'b101,
        TS_BYPASS  = 3'b110,
        TS_QUARTER = 3'b111
    } tsel_e;

    typedef struct packed {
        logic tick;    // any source edge
        logic rise;    // rising source edge
    } src_evt_t;

    function automatic logic pick_div(input logic [NDIV_W-1:0] c, input logic [1:0] code);
        return c[code];
    endfunction

endpackage

// File: rtl/tom_src_sel.sv
module tom_src_sel
    import test_out_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     bypass,
    input  logic     vco_tick,
    input  logic     ser_tick,
    output src_evt_t evt
);
    logic phase_q;   // current level of the selected source

    always_ff @(posedge clk) begin
        if (rst)           phase_q <= 1'b0;
        else if (evt.tick) phase_q <= ~phase_q;
    end

    always_comb begin
        evt.tick = bypass ? ser_tick : vco_tick;
        evt.rise = evt.tick && !phase_q;
    end

    assert_bypass_src_R5: assert property (@(posedge clk) disable iff (rst)
        (bypass && !ser_tick) |=> $stable(phase_q));
    assert_normal_src_R4: assert property (@(posedge clk) disable iff (rst)
        (!bypass && !vco_tick) |=> $stable(phase_q));
endmodule

// File: rtl/tom_mcount.sv
module tom_mcount
    import test_out_pkg::*;
#(
    parameter int W = M_W
)(
    input  logic         clk,
    input  logic         rst,
    input  src_evt_t     evt,
    input  logic [W-1:0] mval,
    output logic         pulse
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            pulse <= 1'b0;
        end else if (evt.rise) begin
            if (mval == '0) begin
                cnt_q <= '0;
                pulse <= 1'b0;
            end else if (cnt_q <= W'(1)) begin
                cnt_q <= mval;
                pulse <= 1'b1;
            end else begin
                cnt_q <= cnt_q - W'(1);
                pulse <= 1'b0;
            end
        end
    end

    assert_zero_m_low_R7: assert property (@(posedge clk) disable iff (rst)
        (evt.rise && mval == '0) |=> !pulse);
    assert_pulse_held_R6: assert property (@(posedge clk) disable iff (rst)
        !evt.rise |=> $stable(pulse));
endmodule

// File: rtl/tom_ndiv.sv
module tom_ndiv
    import test_out_pkg::*;
#(
    parameter int CW = NDIV_W,
    parameter int QW = QDIV_W
)(
    input  logic     clk,
    input  logic     rst,
    input  src_evt_t evt,
    input  logic [1:0] nsel,
    input  logic     clr_q,
    output logic     fout,
    output logic     quarter
);
    logic [CW-1:0] cnt_q;
    logic [QW-1:0] qcnt_q;
    logic          fout_d;

    always_ff @(posedge clk) begin
        if (rst)           cnt_q <= '0;
        else if (evt.tick) cnt_q <= cnt_q + CW'(1);
    end

    assign fout = pick_div(cnt_q, nsel);

    always_ff @(posedge clk) begin
        if (rst) begin
            fout_d <= 1'b0;
            qcnt_q <= '0;
        end else begin
            fout_d <= fout;
            if (clr_q)                qcnt_q <= '0;
            else if (fout && !fout_d) qcnt_q <= qcnt_q + QW'(1);
        end
    end

    assign quarter = qcnt_q[QW-1];

    assert_div_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !evt.tick |=> $stable(cnt_q));
    assert_quarter_clear_R10: assert property (@(posedge clk) disable iff (rst)
        clr_q |=> !quarter);
endmodule

// File: rtl/test_out_mux.sv
module test_out_mux
    import test_out_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       vco_tick,
    input  logic       ser_tick,
    input  logic       ref_in,
    input  logic       shift_in,
    input  logic [2:0] tsel,
    input  logic [1:0] nsel,
    input  logic [8:0] mval,
    output logic       test_pin,
    output logic       fout
);
    tsel_e    code;
    tsel_e    code_q;
    src_evt_t evt;
    logic     m_pulse;
    logic     quarter;
    logic     code_chg;

    assign code = tsel_e'(tsel);

    always_ff @(posedge clk) begin
        if (rst) code_q <= TS_SHIFT;
        else     code_q <= code;
    end

    assign code_chg = (code != code_q);

    tom_src_sel u_src (
        .clk(clk), .rst(rst), .bypass(code == TS_BYPASS),
        .vco_tick(vco_tick), .ser_tick(ser_tick), .evt(evt)
    );

    tom_mcount #(.W(M_W)) u_mcnt (
        .clk(clk), .rst(rst), .evt(evt), .mval(mval), .pulse(m_pulse)
    );

    tom_ndiv #(.CW(NDIV_W), .QW(QDIV_W)) u_ndiv (
        .clk(clk), .rst(rst), .evt(evt), .nsel(nsel),
        .clr_q(code_chg), .fout(fout), .quarter(quarter)
    );

    always_comb begin
        unique case (code)
            TS_SHIFT:   test_pin = shift_in;
            TS_HIGH:    test_pin = 1'b1;
            TS_REF:     test_pin = ref_in;
            TS_MCOUNT:  test_pin = m_pulse;
            TS_FOUT:    test_pin = fout;
            TS_LOW:     test_pin = 1'b0;
            TS_BYPASS:  test_pin = m_pulse;
            TS_QUARTER: test_pin = quarter;
            default:    test_pin = 1'b0;
        endcase
    end

    assert_force_high_R1: assert property (@(posedge clk) disable iff (rst)
        (code == TS_HIGH) |-> test_pin);
    assert_force_low_R1: assert property (@(posedge clk) disable iff (rst)
        (code == TS_LOW) |-> !test_pin);
    assert_reset_fout_R9: assert property (@(posedge clk)
        rst |=> !fout);
endmodule

// File: tb/test_test_out_mux.sv
module test_test_out_mux;
    logic       clk = 1'b0;
    logic       rst;
    logic       vco_tick, ser_tick, ref_in, shift_in;
    logic [2:0] tsel;
    logic [1:0] nsel;
    logic [8:0] mval;
    logic       test_pin, fout;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;   // 250 MHz

    test_out_mux i_test_out_mux (
        .clk(clk), .rst(rst), .vco_tick(vco_tick), .ser_tick(ser_tick),
        .ref_in(ref_in), .shift_in(shift_in), .tsel(tsel), .nsel(nsel),
        .mval(mval), .test_pin(test_pin), .fout(fout)
    );

    // {tsel[2:0], shift_in, ref_in, expected test_pin}
    localparam logic [5:0] VEC [10] = '{
        6'b001_0_0_1, 6'b001_1_1_1, 6'b101_1_1_0, 6'b101_0_0_0,
        6'b000_1_0_1, 6'b000_0_1_0, 6'b010_0_1_1, 6'b010_1_0_0,
        6'b000_1_1_1, 6'b010_0_0_0
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; vco_tick = 0; ser_tick = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic count_fout(input int n, output int t);
        logic prev;
        t = 0;
        prev = fout;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (fout != prev) t++;
            prev = fout;
        end
    endtask

    // clock cycles between two rises of the test pin, -1 when none
    task automatic pin_period(output int p);
        logic prev;
        int   first;
        first = -1;
        p = -1;
        @(negedge clk);
        prev = test_pin;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (test_pin && !prev) begin
                if (first < 0) first = i;
                else begin p = i - first; break; end
            end
            prev = test_pin;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int t, p, ones;
        rst = 1; vco_tick = 0; ser_tick = 0; ref_in = 0; shift_in = 1;
        tsel = 3'b000; nsel = 2'b00; mval = 9'd5;
        do_reset();

        // R9 reset state
        check("R9 fout after reset", fout, 0);
        check("R9 pin after reset (shift path)", test_pin, 1);
        tsel = 3'b011; #1;
        check("R9 M pulse after reset", test_pin, 0);
        tsel = 3'b111; #1;
        check("R9 quarter after reset", test_pin, 0);

        // R1 / R2 vector table
        foreach (VEC[i]) begin
            @(negedge clk);
            tsel = VEC[i][5:3]; shift_in = VEC[i][2]; ref_in = VEC[i][1];
            vco_tick = VEC[i][0]; ser_tick = ~VEC[i][0];
            #1;
            check((VEC[i][5:3] inside {3'b001, 3'b101}) ? "R1 forced level" : "R2 pass-through",
                  test_pin, VEC[i][0]);
        end

        // R3 divide ratios with VCO ticks
        tsel = 3'b100;
        for (int k = 0; k < 4; k++) begin
            nsel = 2'(k);
            do_reset();
            vco_tick = 1;
            count_fout(32, t);
            check($sformatf("R3 toggles for code %0d", k), t, 32 >> k);
        end

        // R4 serial ticks ignored outside bypass
        do_reset();
        nsel = 2'b00; vco_tick = 0; ser_tick = 1;
        count_fout(20, t);
        check("R4 ser_tick ignored", t, 0);

        // R5 bypass: VCO ignored, serial drives
        tsel = 3'b110;
        do_reset();
        vco_tick = 1; ser_tick = 0;
        count_fout(20, t);
        check("R5 vco_tick ignored in bypass", t, 0);
        vco_tick = 0; ser_tick = 1; nsel = 2'b01;
        count_fout(32, t);
        check("R5 serial divides in bypass", t, 16);
        mval = 9'd3;
        pin_period(p);
        check("R5 M pulse on pin in bypass", p, 6);

        // R6 M pulse period and width
        tsel = 3'b011; mval = 9'd5;
        do_reset();
        vco_tick = 1;
        pin_period(p);
        check("R6 M period", p, 10);
        ones = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (test_pin) ones++;
        end
        check("R6 high cycles in 4 periods", ones, 8);

        // R7 zero M holds low
        mval = 9'd0;
        repeat (4) @(negedge clk);
        ones = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (test_pin) ones++;
        end
        check("R7 zero M pulse", ones, 0);

        // R8 quarter rate
        tsel = 3'b111; nsel = 2'b00; mval = 9'd5;
        do_reset();
        vco_tick = 1;
        pin_period(p);
        check("R8 quarter period", p, 8);

        // R10 code change clears quarter counter
        for (int i = 0; i < 20 && !test_pin; i++) @(negedge clk);
        vco_tick = 0;
        @(negedge clk);
        check("R10 quarter high before change", test_pin, 1);
        tsel = 3'b100;
        repeat (2) @(negedge clk);
        tsel = 3'b111;
        repeat (2) @(negedge clk);
        check("R10 quarter cleared", test_pin, 0);

        finish_run();
    end
endmodule